// File: doc/BRIEF.md
# Low Memory Top Decode Register

This block keeps one programmable boundary that marks where usable DRAM ends below 4 GB. The boundary has 1 MB granularity. Software sets it through a small configuration port. Each host address is then compared with it. An address strictly below the boundary is claimed for DRAM. Any address at or above the boundary is left to other decoders.

From the same boundary the block also computes two reserved-region bases that sit one above the other beneath it. The graphics stolen region lies directly below the boundary. The protected region lies directly below the graphics region. Both region sizes are inputs, given in megabytes.

A lock input freezes the register. Once the lock has been seen, it holds until reset. When remapping of reclaimed memory is enabled, the boundary must be 64 MB aligned, and an error output flags a boundary that is not.

Top module: `lowmem_top_decode`

## Requirements
- R1: After reset, `cfg_rdata` reads 16'h0010, which is a boundary of 1 MB.
- R2: Bits 3:0 of `cfg_rdata` always read zero, whatever value was written to them.
- R3: A write takes effect in the cycle after the clock edge that samples `cfg_wr`. `cfg_be[0]` updates register bits 7:4 from `cfg_wdata[7:4]`. `cfg_be[1]` updates register bits 15:8 from `cfg_wdata[15:8]`. A byte whose enable is low keeps its value.
- R4: Register bits 15:4 give host address bits 31:20 of the boundary, and boundary address bits 19:0 are zero. `dram_hit` is high exactly when `host_addr` is strictly less than the boundary. This output is combinational.
- R5: A write is ignored when `lock_in` is high in the same cycle.
- R6: Once `lock_in` has been sampled high, every later write is ignored until reset, even after `lock_in` returns low.
- R7: `cfg_err` is high exactly when `reclaim_en` is high and register bits 9:4 are not all zero, that is, when the boundary is not 64 MB aligned.
- R8: `gfx_base` equals the boundary minus `gfx_size` megabytes, computed modulo 4 GB.
- R9: `prot_base` equals `gfx_base` minus `prot_size` megabytes, computed modulo 4 GB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current register value |
| lock_in | input | 1 | Lock request; becomes sticky once sampled |
| reclaim_en | input | 1 | Reclaim remapping enabled; demands 64 MB alignment |
| host_addr | input | 32 | Host address to decode |
| dram_hit | output | 1 | Address lies below the boundary |
| gfx_size | input | 12 | Graphics stolen size in MB |
| prot_size | input | 12 | Protected region size in MB |
| gfx_base | output | 32 | Graphics stolen region base |
| prot_base | output | 32 | Protected region base |
| cfg_err | output | 1 | Misaligned boundary while reclaim is enabled |

## Verification
The decode is probed at three points: the last byte below the boundary, the boundary itself, and the first byte of the region just above it. This separates a strict comparison from a less-or-equal comparison, and it catches a mistake that compares only part of the address. Partial writes through each byte enable are run on their own, so that swapped or merged lanes can be told apart. Writes are tried with the lock held, after the lock has been released, and again after a fresh reset; this tells a sticky lock from a level lock. The base outputs are checked with small sizes and with a size larger than the boundary, which exposes how subtraction wrap-around is handled.

// File: rtl/lowmem_top_decode.sv
module lowmem_top_decode #(
  parameter int ADDR_W  = 32,
  parameter int GRAN_W  = 20,
  parameter int ALIGN_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_be,
  input  logic [15:0]        cfg_wdata,
  output logic [15:0]        cfg_rdata,
  input  logic               lock_in,
  input  logic               reclaim_en,
  input  logic [ADDR_W-1:0]  host_addr,
  output logic               dram_hit,
  input  logic [11:0]        gfx_size,
  input  logic [11:0]        prot_size,
  output logic [ADDR_W-1:0]  gfx_base,
  output logic [ADDR_W-1:0]  prot_base,
  output logic               cfg_err
);
  localparam int FIELD_W = ADDR_W - GRAN_W;

  logic [FIELD_W-1:0] bound_q;
  logic               locked_q;
  logic               wr_ok;
  logic [FIELD_W-1:0] gfx_mb, prot_mb;

  assign wr_ok = cfg_wr && !lock_in && !locked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bound_q  <= FIELD_W'(1);
      locked_q <= 1'b0;
    end else begin
      if (lock_in) locked_q <= 1'b1;
      if (wr_ok && cfg_be[0]) bound_q[3:0] <= cfg_wdata[7:4];
      if (wr_ok && cfg_be[1]) bound_q[FIELD_W-1:4] <= cfg_wdata[15:8];
    end
  end

  assign cfg_rdata = {bound_q, 4'h0};
  assign dram_hit  = host_addr[ADDR_W-1:GRAN_W] < bound_q;
  assign cfg_err   = reclaim_en && (bound_q[ALIGN_W-1:0] != '0);
  assign gfx_mb    = bound_q - gfx_size;
  assign prot_mb   = gfx_mb - prot_size;
  assign gfx_base  = {gfx_mb, {GRAN_W{1'b0}}};
  assign prot_base = {prot_mb, {GRAN_W{1'b0}}};

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_be == 2'b11 && !lock_in && !locked_q)
      |=> cfg_rdata[15:4] == $past(cfg_wdata[15:4]));

  assert_locked_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_in || locked_q) |=> $stable(cfg_rdata));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_in |=> locked_q);

  assert_err_needs_reclaim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> reclaim_en);

  assert_hit_vs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dram_hit == (host_addr < {cfg_rdata[15:4], {GRAN_W{1'b0}}}));

  assert_gfx_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_base + {gfx_size, {GRAN_W{1'b0}}}) == {cfg_rdata[15:4], {GRAN_W{1'b0}}});
endmodule

// File: tb/test_lowmem_top_decode.sv
module test_lowmem_top_decode;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] rdata;
    logic        hit;
    logic        err;
    logic [31:0] gbase;
    logic [31:0] pbase;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, lock_in = 1'b0, reclaim_en = 1'b0;
  logic [1:0] cfg_be = 2'b00;
  logic [15:0] cfg_wdata = '0;
  logic [31:0] host_addr = '0;
  logic [11:0] gfx_size = '0, prot_size = '0;
  logic [15:0] cfg_rdata;
  logic dram_hit, cfg_err;
  logic [31:0] gfx_base, prot_base;

  int checks = 0, errors = 0;
  exp_t sb[$];
  logic [11:0] m_bound = 12'h001;
  logic m_locked = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowmem_top_decode i_lowmem_top_decode (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lock_in(lock_in),
    .reclaim_en(reclaim_en), .host_addr(host_addr), .dram_hit(dram_hit),
    .gfx_size(gfx_size), .prot_size(prot_size), .gfx_base(gfx_base),
    .prot_base(prot_base), .cfg_err(cfg_err));

  task automatic do_reset();
    @(negedge clk); #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    m_bound = 12'h001; m_locked = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] be, input logic [15:0] d, input logic lk);
    @(negedge clk); #2;
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d; lock_in = lk;
    @(posedge clk); #1;
    cfg_wr = 1'b0; lock_in = 1'b0;
    if (!lk && !m_locked) begin
      if (be[0]) m_bound[3:0]  = d[7:4];
      if (be[1]) m_bound[11:4] = d[15:8];
    end
    if (lk) m_locked = 1'b1;
  endtask

  task automatic probe(input logic [31:0] a, input string tag);
    exp_t e;
    logic [11:0] g;
    @(negedge clk); #2;
    host_addr = a;
    g = m_bound - gfx_size;
    e.rdata = {m_bound, 4'h0};
    e.hit   = a < {m_bound, 20'h0};
    e.err   = reclaim_en && (m_bound[5:0] != 6'h0);
    e.gbase = {g, 20'h0};
    e.pbase = {12'(g - prot_size), 20'h0};
    e.tag   = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (cfg_rdata !== e.rdata || dram_hit !== e.hit || cfg_err !== e.err ||
            gfx_base !== e.gbase || prot_base !== e.pbase) begin
          errors++;
          $display("FAIL %s: got rdata=%h hit=%b err=%b gbase=%h pbase=%h, expected rdata=%h hit=%b err=%b gbase=%h pbase=%h",
                   e.tag, cfg_rdata, dram_hit, cfg_err, gfx_base, prot_base,
                   e.rdata, e.hit, e.err, e.gbase, e.pbase);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    do_reset();
    probe(32'h0000_0000, "R1 reset value, address zero");
    probe(32'h000F_FFFF, "R4 last byte below reset boundary");
    probe(32'h0010_0000, "R4 boundary itself is not DRAM");
    do_write(2'b11, 16'hECBF, 1'b0);
    probe(32'hECAF_FFFF, "R2 R3 full write, low nibble reads zero");
    probe(32'hECB0_0000, "R4 equal to boundary misses");
    probe(32'hFFFF_FFFF, "R4 top address misses");
    do_write(2'b01, 16'h55A0, 1'b0);
    probe(32'hECA0_0000, "R3 low byte enable only");
    do_write(2'b10, 16'h41FF, 1'b0);
    probe(32'h4190_0000, "R3 high byte enable only");
    gfx_size = 12'h020; prot_size = 12'h008;
    probe(32'h3FA0_0000, "R8 R9 stacked bases");
    reclaim_en = 1'b1;
    probe(32'h0, "R7 unaligned with reclaim flags error");
    do_write(2'b11, 16'h4000, 1'b0);
    probe(32'h0, "R7 aligned with reclaim clears error");
    gfx_size = 12'h500; prot_size = 12'h100;
    probe(32'h3FFF_FFFF, "R8 R9 wrap modulo 4 GB");
    reclaim_en = 1'b0;
    do_write(2'b11, 16'h0130, 1'b0);
    probe(32'h0, "R7 unaligned without reclaim has no error");
    gfx_size = 12'h000; prot_size = 12'h000;
    do_write(2'b11, 16'h8000, 1'b1);
    probe(32'h0130_0000, "R5 write with lock held ignored");
    do_write(2'b11, 16'h8000, 1'b0);
    probe(32'h0130_0000, "R6 lock sticky after release");
    do_reset();
    probe(32'h0010_0000, "R1 R6 reset restores value and unlocks");
    do_write(2'b11, 16'h2000, 1'b0);
    probe(32'h1FFF_FFFF, "R6 write works after reset");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule